// File: doc/BRIEF.md
# Indirect Window Port with Address Stepping

This block gives a host a two-register window into a device. One host register holds a pointer (a 14-bit byte address, a target select bit and a step-enable bit). The other host register is the data window. A read or write of the data window goes to whatever the pointer selects. The target is either a bank of 32-bit control registers that sits outside the block, or an on-chip RAM held inside the block. Each RAM row is 68 bits wide, so it is wider than the 32-bit host bus.

The pointer is split in one of two ways. For the register bank, bits 6:2 pick one of 32 registers. For the RAM, bits 10:2 pick a row and bits 1:0 pick which slice of that row is seen. With step enabled, the pointer moves forward by 4 after every data-window access, so a host can stream through consecutive registers, or through consecutive rows at a fixed slice, without rewriting the pointer.

RAM traffic is allowed only while the surrounding adapter is held in reset, as reported on `adapter_in_reset`. A RAM access made outside that state has no effect on the RAM contents.

Top module: `iap_port`

## Requirements
- R1: After reset the pointer register reads 0x00000000. A host write to the pointer (`host_data_sel`=0) updates bits 7:0 under `host_be[0]` and bits 15:8 under `host_be[1]`. Reading the pointer returns its 16 bits zero-extended, and such a read does not move the pointer.
- R2: The pointer layout is bit 15 = step enable, bit 14 = RAM select, bits 13:0 = byte address. With bit 15 set, every data-window read or write adds 4 to bits 13:0 modulo 2^14, taking effect after the access. Bits 15:14 do not change.
- R3: With bit 15 clear, data-window accesses leave the pointer unchanged.
- R4: With bit 14 clear, a data access drives `reg_addr` = pointer bits 6:2 in the same cycle, ignoring bits 13:7 and 1:0. It also pulses `reg_wr` or `reg_rd` and passes `host_be` and `host_wdata` through. A read returns `reg_rdata`.
- R5: With bit 14 set, the row is pointer bits 10:2, and bits 13:11 are ignored. The slice is pointer bits 1:0: 0 maps to row bits 31:0, 1 to bits 63:32, and 2 to bits 67:64 on data bits 3:0 (upper data bits read zero). Slice 3 reads zero and ignores writes.
- R6: On a RAM write, byte lane k of the data is written only when `host_be[k]` is set. Slice 2 is written only through lane 0, data bits 3:0.
- R7: A RAM write takes effect only if `adapter_in_reset` is 1 in the cycle of the access. A RAM read made while it is 0 returns zero.
- R8: RAM rows 431 and above read zero and ignore writes. Row 430 is a normal row.
- R9: `host_rvalid` is high exactly in the cycle after a read strobe that has no write strobe alongside it. `host_rdata` carries the result then and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adapter_in_reset | input | 1 | High while the adapter is held in reset; opens the RAM |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_data_sel | input | 1 | 1 = data window, 0 = pointer register |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read result |
| host_rvalid | output | 1 | Read result valid |
| reg_addr | output | 5 | Register index for the control register bank |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_be | output | 4 | Register byte enables |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data from the bank |

## Verification
Two functions can meet in one clock edge: a RAM write, and a change of `adapter_in_reset` that opens or closes the RAM. The bench drops `adapter_in_reset` on the same edge as a RAM write, and separately raises it on the same edge as another write. The outcome is judged by reading the row back with the RAM open. The first write must be absent and the second present, because the gate is sampled in the access cycle itself.

// File: rtl/iap_pkg.sv
package iap_pkg;

  localparam int ADR_W     = 14;
  localparam int CTL_W     = ADR_W + 2;
  localparam int ROW_IDX_W = 9;
  localparam int PART_W    = 2;
  localparam int REG_IDX_W = 5;
  localparam int STEP_BYTES = 4;

  typedef struct packed {
    logic             step_en;
    logic             ram_sel;
    logic [ADR_W-1:0] adr;
  } iap_ctl_t;

  // byte address after one data-window access, wrapping in ADR_W bits
  function automatic logic [ADR_W-1:0] adr_next(input logic [ADR_W-1:0] a);
    return a + ADR_W'(STEP_BYTES);
  endfunction

  function automatic logic [ROW_IDX_W-1:0] row_of(input logic [ADR_W-1:0] a);
    return a[ROW_IDX_W+PART_W-1:PART_W];
  endfunction

  function automatic logic [PART_W-1:0] part_of(input logic [ADR_W-1:0] a);
    return a[PART_W-1:0];
  endfunction

  function automatic logic [REG_IDX_W-1:0] reg_of(input logic [ADR_W-1:0] a);
    return a[REG_IDX_W+1:2];
  endfunction

endpackage

// File: rtl/iap_addr_reg.sv
module iap_addr_reg
  import iap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [1:0]       ctl_be,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             data_access,
  output iap_ctl_t         ctl_q
);

  logic [CTL_W-1:0] bits_q;
  iap_ctl_t         cur;

  assign cur   = iap_ctl_t'(bits_q);
  assign ctl_q = cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (ctl_wr) begin
      if (ctl_be[0]) bits_q[7:0]  <= ctl_wdata[7:0];
      if (ctl_be[1]) bits_q[15:8] <= ctl_wdata[15:8];
    end else if (data_access && cur.step_en) begin
      bits_q[ADR_W-1:0] <= adr_next(cur.adr);
    end
  end

endmodule

// File: rtl/iap_decode.sv
module iap_decode
  import iap_pkg::*;
#(
  parameter int ROWS  = 431,
  parameter int NPART = 3
) (
  input  iap_ctl_t               ctl,
  input  logic                   data_wr,
  input  logic                   data_rd,
  input  logic                   adapter_in_reset,
  output logic [REG_IDX_W-1:0]   reg_idx,
  output logic                   reg_hit_wr,
  output logic                   reg_hit_rd,
  output logic [ROW_IDX_W-1:0]   ram_row,
  output logic [PART_W-1:0]      ram_part,
  output logic                   ram_we,
  output logic                   ram_rd_ok,
  output logic                   ram_wr_blocked
);

  logic row_ok;
  logic part_ok;
  logic ram_open;
  logic unused_hi;

  assign reg_idx  = reg_of(ctl.adr);
  assign ram_row  = row_of(ctl.adr);
  assign ram_part = part_of(ctl.adr);

  assign row_ok   = 32'(ram_row) < ROWS;
  assign part_ok  = 32'(ram_part) < NPART;
  assign ram_open = ctl.ram_sel && adapter_in_reset && row_ok && part_ok;

  assign reg_hit_wr     = data_wr && !ctl.ram_sel;
  assign reg_hit_rd     = data_rd && !ctl.ram_sel;
  assign ram_we         = data_wr && ram_open;
  assign ram_rd_ok      = data_rd && ram_open;
  assign ram_wr_blocked = data_wr && ctl.ram_sel && !ram_open;

  assign unused_hi = ^ctl.adr[ADR_W-1:ROW_IDX_W+PART_W];

endmodule

// File: rtl/iap_ram.sv
module iap_ram
  import iap_pkg::*;
#(
  parameter int ROWS  = 431,
  parameter int ROW_W = 68,
  parameter int BUS_W = 32
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [ROW_IDX_W-1:0] row,
  input  logic [PART_W-1:0]    part,
  input  logic [BUS_W/8-1:0]   be,
  input  logic [BUS_W-1:0]     wdata,
  output logic [BUS_W-1:0]     rword
);

  localparam int NPART = (ROW_W + BUS_W - 1) / BUS_W;
  localparam int EXT_W = NPART * BUS_W;
  localparam int LANES = BUS_W / 8;

  logic [ROW_W-1:0] mem [ROWS];

  logic [BUS_W-1:0] lane_mask;
  logic [EXT_W-1:0] ext_mask;
  logic [EXT_W-1:0] ext_data;
  logic [EXT_W-1:0] ext_row;
  logic [EXT_W-1:0] ext_rd;
  logic [ROW_W-1:0] row_now;
  int               shift;

  always_comb begin
    for (int b = 0; b < LANES; b++) begin
      lane_mask[8*b +: 8] = {8{be[b]}};
    end
  end

  assign shift    = 32'(part) * BUS_W;
  assign ext_mask = EXT_W'(lane_mask) << shift;
  assign ext_data = EXT_W'(wdata) << shift;
  assign row_now  = mem[row];
  assign ext_row  = EXT_W'(row_now);
  assign ext_rd   = ext_row >> shift;
  assign rword    = ext_rd[BUS_W-1:0];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[row] <= (row_now & ~ext_mask[ROW_W-1:0]) | (ext_data[ROW_W-1:0] & ext_mask[ROW_W-1:0]);
    end
  end

endmodule

// File: rtl/iap_port.sv
module iap_port
  import iap_pkg::*;
#(
  parameter int ROWS  = 431,
  parameter int ROW_W = 68,
  parameter int BUS_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adapter_in_reset,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic                 host_data_sel,
  input  logic [BUS_W/8-1:0]   host_be,
  input  logic [BUS_W-1:0]     host_wdata,
  output logic [BUS_W-1:0]     host_rdata,
  output logic                 host_rvalid,
  output logic [REG_IDX_W-1:0] reg_addr,
  output logic                 reg_wr,
  output logic                 reg_rd,
  output logic [BUS_W/8-1:0]   reg_be,
  output logic [BUS_W-1:0]     reg_wdata,
  input  logic [BUS_W-1:0]     reg_rdata
);

  localparam int NPART = (ROW_W + BUS_W - 1) / BUS_W;

  // named internal events
  logic rd_fire;
  logic ctl_wr;
  logic ctl_rd;
  logic data_wr;
  logic data_rd;
  logic data_access;
  logic ram_we;
  logic ram_rd_ok;
  logic ram_wr_blocked;

  iap_ctl_t              ctl;
  logic [CTL_W-1:0]      ctl_bits;
  logic [ROW_IDX_W-1:0]  ram_row;
  logic [PART_W-1:0]     ram_part;
  logic [BUS_W-1:0]      ram_rword;
  logic [BUS_W-1:0]      rd_mux;

  assign rd_fire     = host_rd && !host_wr;
  assign ctl_wr      = host_wr && !host_data_sel;
  assign ctl_rd      = rd_fire && !host_data_sel;
  assign data_wr     = host_wr && host_data_sel;
  assign data_rd     = rd_fire && host_data_sel;
  assign data_access = data_wr || data_rd;
  assign ctl_bits    = CTL_W'(ctl);

  iap_addr_reg u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_be      (host_be[1:0]),
    .ctl_wdata   (host_wdata[CTL_W-1:0]),
    .data_access (data_access),
    .ctl_q       (ctl)
  );

  iap_decode #(.ROWS(ROWS), .NPART(NPART)) u_dec (
    .ctl              (ctl),
    .data_wr          (data_wr),
    .data_rd          (data_rd),
    .adapter_in_reset (adapter_in_reset),
    .reg_idx          (reg_addr),
    .reg_hit_wr       (reg_wr),
    .reg_hit_rd       (reg_rd),
    .ram_row          (ram_row),
    .ram_part         (ram_part),
    .ram_we           (ram_we),
    .ram_rd_ok        (ram_rd_ok),
    .ram_wr_blocked   (ram_wr_blocked)
  );

  iap_ram #(.ROWS(ROWS), .ROW_W(ROW_W), .BUS_W(BUS_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .row   (ram_row),
    .part  (ram_part),
    .be    (host_be),
    .wdata (host_wdata),
    .rword (ram_rword)
  );

  assign reg_be    = host_be;
  assign reg_wdata = host_wdata;

  always_comb begin
    if (ctl_rd)              rd_mux = BUS_W'(ctl_bits);
    else if (!ctl.ram_sel)   rd_mux = reg_rdata;
    else if (ram_rd_ok)      rd_mux = ram_rword;
    else                     rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_fire;
      if (rd_fire) host_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/iap_chk.sv
module iap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic        host_rd,
  input logic        host_data_sel,
  input logic        adapter_in_reset,
  input logic        host_rvalid,
  input logic [31:0] host_rdata,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [15:0] ctl_bits,
  input logic        ram_we
);

  // R2
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_data_sel && (host_wr || host_rd) && ctl_bits[15])
      |=> (ctl_bits[13:0] == 14'($past(ctl_bits[13:0]) + 14'd4)));

  // R3
  no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_data_sel && (host_wr || host_rd) && !ctl_bits[15]) |=> $stable(ctl_bits));

  // R4
  reg_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> (host_data_sel && !ctl_bits[14]));

  // R7
  ram_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> adapter_in_reset);

  // R7
  closed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_data_sel && ctl_bits[14] && !adapter_in_reset)
      |=> (host_rdata == 32'h0));

  // R9
  rvalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr) |=> host_rvalid);

  // R9
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && !host_wr) |=> !host_rvalid);

endmodule

bind iap_port iap_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .host_wr          (host_wr),
  .host_rd          (host_rd),
  .host_data_sel    (host_data_sel),
  .adapter_in_reset (adapter_in_reset),
  .host_rvalid      (host_rvalid),
  .host_rdata       (host_rdata),
  .reg_wr           (reg_wr),
  .reg_rd           (reg_rd),
  .ctl_bits         (ctl_bits),
  .ram_we           (ram_we)
);

// File: tb/sim_iap_port.sv
`timescale 1ns/1ps
module sim_iap_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adapter_in_reset = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic        host_data_sel = 1'b0;
  logic [3:0]  host_be = 4'h0;
  logic [31:0] host_wdata = 32'h0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic [4:0]  reg_addr;
  logic        reg_wr;
  logic        reg_rd;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  logic [31:0] bregs [32];

  always #2.5 clk = ~clk;

  iap_port u0 (
    .clk (clk), .rst_n (rst_n), .adapter_in_reset (adapter_in_reset),
    .host_wr (host_wr), .host_rd (host_rd), .host_data_sel (host_data_sel),
    .host_be (host_be), .host_wdata (host_wdata), .host_rdata (host_rdata),
    .host_rvalid (host_rvalid), .reg_addr (reg_addr), .reg_wr (reg_wr),
    .reg_rd (reg_rd), .reg_be (reg_be), .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
  );

  // external register bank model
  assign reg_rdata = bregs[reg_addr];
  always @(posedge clk) begin
    if (reg_wr) begin
      for (int b = 0; b < 4; b++)
        if (reg_be[b]) bregs[reg_addr][8*b +: 8] <= reg_wdata[8*b +: 8];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (host_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected rvalid", 32'h1, 32'h0);
      end else begin
        check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr_ptr(input logic [15:0] v, input logic [1:0] be = 2'b11);
    @(negedge clk);
    host_wr = 1'b1; host_data_sel = 1'b0; host_be = {2'b00, be}; host_wdata = {16'h0, v};
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wr_data(input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    host_wr = 1'b1; host_data_sel = 1'b1; host_be = be; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    host_rd = 1'b1; host_data_sel = sel;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) bregs[i] = 32'h2222_0000 | i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 rvalid low after reset", {31'h0, host_rvalid}, 32'h0);
    rd(1'b0, 32'h0000_0000, "R1 pointer reset value");

    // register window with stepping
    wr_ptr(16'hBF84);
    @(negedge clk);
    host_wr = 1'b1; host_data_sel = 1'b1; host_be = 4'hF; host_wdata = 32'hA5A5_1234;
    #1;
    check("R4 reg_addr from bits 6:2", {27'h0, reg_addr}, 32'd1);
    check("R4 reg_wr strobe", {31'h0, reg_wr}, 32'd1);
    @(negedge clk);
    host_wr = 1'b0;
    rd(1'b0, 32'h0000_BF88, "R2 step after write");
    rd(1'b1, 32'h2222_0002, "R4 read next register");
    rd(1'b0, 32'h0000_BF8C, "R2 step after read");

    // no stepping, byte enables toward register bank
    wr_ptr(16'h3F84);
    rd(1'b1, 32'hA5A5_1234, "R4 register readback");
    wr_data(32'hFFFF_FFFF, 4'b0101);
    rd(1'b1, 32'hA5FF_12FF, "R4 register byte enables");
    rd(1'b0, 32'h0000_3F84, "R3 pointer unchanged");
    wr_ptr(16'h0011, 2'b01);
    rd(1'b0, 32'h0000_3F11, "R1 pointer low byte only");

    // RAM slices, aliased high bits
    adapter_in_reset = 1'b1;
    wr_ptr(16'h7814); wr_data(32'h1122_3344);
    wr_ptr(16'h7815); wr_data(32'h5566_7788);
    wr_ptr(16'h7816); wr_data(32'hFFFF_FFFB);
    wr_ptr(16'h7817); wr_data(32'hDEAD_BEEF);
    wr_ptr(16'h4014); rd(1'b1, 32'h1122_3344, "R5 slice 0 via alias");
    wr_ptr(16'h4015); rd(1'b1, 32'h5566_7788, "R5 slice 1");
    wr_ptr(16'h4016); rd(1'b1, 32'h0000_000B, "R5 slice 2 nibble");
    wr_ptr(16'h4017); rd(1'b1, 32'h0000_0000, "R5 slice 3 reads zero");

    // RAM byte enables
    wr_ptr(16'h4014); wr_data(32'h0000_AA00, 4'b0010);
    rd(1'b1, 32'h1122_AA44, "R6 lane 1 only");
    wr_ptr(16'h4016); wr_data(32'h0000_0005, 4'b1110);
    rd(1'b1, 32'h0000_000B, "R6 slice 2 needs lane 0");

    // stepping through rows
    wr_ptr(16'hC014);
    rd(1'b1, 32'h1122_AA44, "R2 RAM read with step");
    wr_data(32'h0000_0066);
    rd(1'b0, 32'h0000_C01C, "R2 RAM pointer stepped twice");
    wr_ptr(16'h4018);
    rd(1'b1, 32'h0000_0066, "R2 stepped write landed on next row");

    // row range
    wr_ptr(16'h46BC); wr_data(32'h1234_5678);
    rd(1'b1, 32'h0000_0000, "R8 row 431 reads zero");
    wr_ptr(16'h46B8); wr_data(32'h0BAD_F00D);
    rd(1'b1, 32'h0BAD_F00D, "R8 row 430 usable");

    // gate closed
    adapter_in_reset = 1'b0;
    wr_ptr(16'h4014);
    rd(1'b1, 32'h0000_0000, "R7 closed read zero");
    wr_data(32'h9999_9999);
    adapter_in_reset = 1'b1;
    rd(1'b1, 32'h1122_AA44, "R7 closed write ignored");

    // gate changes on the same edge as a write
    wr_ptr(16'h4018);
    @(negedge clk);
    adapter_in_reset = 1'b0;
    host_wr = 1'b1; host_data_sel = 1'b1; host_be = 4'hF; host_wdata = 32'h77;
    @(negedge clk);
    host_wr = 1'b0; adapter_in_reset = 1'b1;
    rd(1'b1, 32'h0000_0066, "R7 write as gate closes");
    adapter_in_reset = 1'b0;
    @(negedge clk);
    adapter_in_reset = 1'b1;
    host_wr = 1'b1; host_data_sel = 1'b1; host_be = 4'hF; host_wdata = 32'h88;
    @(negedge clk);
    host_wr = 1'b0;
    rd(1'b1, 32'h0000_0088, "R7 write as gate opens");

    // wrap of the byte address
    wr_ptr(16'hBFFC);
    rd(1'b1, 32'h2222_001F, "R4 last register");
    rd(1'b0, 32'h0000_8000, "R2 address wraps");

    // hold of read data
    repeat (3) @(negedge clk);
    check("R9 rdata held", host_rdata, 32'h0000_8000);
    check("R9 rvalid idle", {31'h0, host_rvalid}, 32'h0);
    check("R9 scoreboard drained", exp_q.size(), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule